// File: doc/BRIEF.md
# Serial Register Access Master

This block is the host-side engine that reads and writes single registers of an external transceiver over a four-wire serial bus. A client hands it one request at a time through a valid/ready handshake. The request carries an operation code, a 6-bit register address, a bit mask, a bit position and a write value. When the work is finished the block returns a one-cycle `done` pulse and a result byte.

There are four operations. A plain read and a plain write each take one bus frame. A field read takes one frame and returns only the masked bits, aligned down to bit 0. A field update is a read-modify-write: the block reads the register, merges in the new field and writes the result back in a second frame. No other request can start between those two frames.

Every frame is sixteen bits long: a command byte, then a data byte. The select line stays low for the whole frame. The serial clock is derived from the system clock through a programmable half-period divider.

Top module: `spi_reg_master`

## Requirements
- R1: A plain read (`req_op`=0) sends the command byte 0x80 OR the address, then the byte 0x00. The byte shifted in during the second byte is returned on `rdata` with `done`.
- R2: A plain write (`req_op`=1) sends the command byte 0xC0 OR the address, then `req_wdata`. `rdata` returns the byte written.
- R3: `ss_n` idles high. It goes low for exactly one frame per bus transaction, and exactly 16 rising `sck` edges occur while it is low.
- R4: Bits go out most significant first in SPI mode 0. `sck` is low whenever `ss_n` is high. `mosi` changes only after a falling edge, and `miso` is sampled at the rising edge.
- R5: A field read (`req_op`=2) issues one read frame and returns (register AND `req_mask`) shifted right by `req_pos`.
- R6: A field update (`req_op`=3) issues a read frame, then a write frame to the same address. The write frame carries (register AND NOT mask) OR ((`req_wdata` << `req_pos`) AND mask). `rdata` returns that merged byte.
- R7: `req_ready` is low from the cycle after acceptance until `done`. A request held valid meanwhile is taken only afterwards, and none of its frames falls between the two frames of a field update.
- R8: Between two frames, `ss_n` stays high for at least 2*(`half_period`+1) clock cycles.
- R9: `busy` is high from the cycle after acceptance until the cycle `done` pulses. `done` lasts one cycle, with `busy` low.
- R10: Every `sck` level, and the lead time from the fall of `ss_n` to the first rising edge, lasts `half_period`+1 clock cycles.
- R11: After reset, `ss_n`=1, `sck`=0, `busy`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_period | input | 8 | Serial clock half period, in system clocks, minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 field read, 3 field update |
| req_addr | input | 6 | Register address |
| req_mask | input | 8 | Field mask (field operations) |
| req_pos | input | 3 | Field bit position (field operations) |
| req_wdata | input | 8 | Write data or field value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Result byte, valid with done |
| ss_n | output | 1 | Active-low select |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can coincide: a field update's first frame completing, and a new request waiting at the request port. In that cycle the block must launch its own write-back frame rather than accept the waiting request. The bench provokes this by holding a plain write to the same address valid through an entire field update. It then judges the result from the serial frame log and the final register content. The log must show read, merged write, then the plain write, and the register must hold the plain write's value. Around that case, the bench sweeps all addresses and every contiguous mask at every position, under three divider settings, against an arithmetic model of the register file.

// File: rtl/spireg_pkg.sv
// Package: operation codes and command-byte opcode bits shared by the
// serial register master. Assumes a 6-bit address under a 2-bit opcode.
package spireg_pkg;
    typedef enum logic [1:0] {
        OP_REG_RD = 2'd0,
        OP_REG_WR = 2'd1,
        OP_FLD_RD = 2'd2,
        OP_FLD_WR = 2'd3
    } op_e;

    localparam logic [1:0] CMD_READ  = 2'b10;
    localparam logic [1:0] CMD_WRITE = 2'b11;
endpackage

// File: rtl/spireg_clkdiv.sv
// Half-period tick generator. While run is high it emits one tick every
// half_period+1 cycles, first tick half_period+1 cycles after run rises.
// Assumes half_period is held constant while run is high.
module spireg_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_period);

    // count cycles within one half period, restart on tick or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R10: with a non-zero divider, two ticks are never adjacent
    p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_period != '0) ##1 $stable(half_period) |-> !tick);
endmodule

// File: rtl/spireg_shifter.sv
// Frame engine: on start, pulls ss_n low and shifts a FRAME_W-bit word out
// MSB first in SPI mode 0, capturing miso on each rising sck edge. It then
// raises ss_n and waits one full sck period before pulsing done.
// Assumes start arrives only while idle is high.
module spireg_shifter #(
    parameter int FRAME_W = 16,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   half_period,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               idle,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               ss_n,
    output logic               sck,
    output logic               mosi,
    input  logic               miso
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_HIGH, SH_LOW, SH_TRAIL, SH_GAP} sh_state_e;

    sh_state_e          state;
    logic [FRAME_W-1:0] tx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               gap_cnt;
    logic               tick;

    spireg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state != SH_IDLE),
        .half_period(half_period),
        .tick       (tick)
    );

    assign idle = (state == SH_IDLE);
    assign mosi = tx_sh[FRAME_W-1];

    // frame sequencing: select, clock edges, bit shifting and guard time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            tx_sh   <= '0;
            rx_word <= '0;
            bit_cnt <= '0;
            gap_cnt <= 1'b0;
            ss_n    <= 1'b1;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SH_IDLE: if (start) begin
                    ss_n    <= 1'b0;
                    tx_sh   <= tx_word;
                    bit_cnt <= '0;
                    state   <= SH_LEAD;
                end
                SH_LEAD, SH_LOW: if (tick) begin
                    sck     <= 1'b1;
                    rx_word <= {rx_word[FRAME_W-2:0], miso};
                    state   <= SH_HIGH;
                end
                SH_HIGH: if (tick) begin
                    sck <= 1'b0;
                    if (bit_cnt == LAST_BIT) begin
                        state <= SH_TRAIL;
                    end else begin
                        tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= SH_LOW;
                    end
                end
                SH_TRAIL: if (tick) begin
                    ss_n    <= 1'b1;
                    gap_cnt <= 1'b0;
                    state   <= SH_GAP;
                end
                SH_GAP: if (tick) begin
                    if (gap_cnt) begin
                        done  <= 1'b1;
                        state <= SH_IDLE;
                    end else begin
                        gap_cnt <= 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R4: the clock rests low whenever the select is released
    p_sck_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sck);
    // R10: sck only moves on a divider tick
    p_sck_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |-> $past(tick));
    // R4: mosi never changes while sck is high
    p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
    // R8: completion comes only after select has been high for a while
    p_done_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_n && $past(ss_n)));
endmodule

// File: rtl/spireg_seq.sv
// Request sequencer: takes one request, builds the command word from the
// opcode bits and address, runs one frame (or two for a field update) and
// forms the result. Assumes the frame engine returns to idle with done.
module spireg_seq #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_mask,
    input  logic [$clog2(DATA_W)-1:0] req_pos,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic                  xfer_start,
    output logic [2*DATA_W-1:0]   xfer_word,
    input  logic                  xfer_idle,
    input  logic                  xfer_done,
    input  logic [2*DATA_W-1:0]   xfer_rx
);
    import spireg_pkg::*;

    localparam int POS_W = $clog2(DATA_W);

    typedef enum logic [1:0] {SQ_IDLE, SQ_FIRST, SQ_SECOND} sq_state_e;

    sq_state_e         state;
    op_e               lat_op;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_mask;
    logic [POS_W-1:0]  lat_pos;
    logic [DATA_W-1:0] lat_val;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] merged;

    assign req_ready = (state == SQ_IDLE);
    assign busy      = (state != SQ_IDLE);
    assign rx_byte   = xfer_rx[DATA_W-1:0];

    // read-modify-write merge of the captured register and the new field
    always_comb begin
        merged = (rx_byte & ~lat_mask) | ((lat_val << lat_pos) & lat_mask);
    end

    // request acceptance, frame launch and result formation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            lat_op     <= OP_REG_RD;
            lat_addr   <= '0;
            lat_mask   <= '0;
            lat_pos    <= '0;
            lat_val    <= '0;
            xfer_start <= 1'b0;
            xfer_word  <= '0;
            done       <= 1'b0;
            rdata      <= '0;
        end else begin
            xfer_start <= 1'b0;
            done       <= 1'b0;
            case (state)
                SQ_IDLE: if (req_valid) begin
                    lat_op     <= op_e'(req_op);
                    lat_addr   <= req_addr;
                    lat_mask   <= req_mask;
                    lat_pos    <= req_pos;
                    lat_val    <= req_wdata;
                    xfer_start <= 1'b1;
                    if (op_e'(req_op) == OP_REG_WR)
                        xfer_word <= {CMD_WRITE, req_addr, req_wdata};
                    else
                        xfer_word <= {CMD_READ, req_addr, {DATA_W{1'b0}}};
                    state <= SQ_FIRST;
                end
                SQ_FIRST: if (xfer_done) begin
                    case (lat_op)
                        OP_REG_RD: begin
                            rdata <= rx_byte;
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end
                        OP_REG_WR: begin
                            rdata <= lat_val;
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end
                        OP_FLD_RD: begin
                            rdata <= (rx_byte & lat_mask) >> lat_pos;
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end
                        default: begin
                            rdata      <= merged;
                            xfer_word  <= {CMD_WRITE, lat_addr, merged};
                            xfer_start <= 1'b1;
                            state      <= SQ_SECOND;
                        end
                    endcase
                end
                SQ_SECOND: if (xfer_done) begin
                    done  <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R7: a frame is launched only into an idle frame engine
    p_start_into_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> xfer_idle);
    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: completion coincides with the end of busy
    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R6: the second frame of an update follows a completed first frame
    p_rmw_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && busy && $past(busy)) |-> $past(xfer_done));
endmodule

// File: rtl/spi_reg_master.sv
// Top: serial register access master. Joins the request sequencer to the
// frame engine. Assumes half_period is changed only while busy is low.
module spi_reg_master #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIV_W-1:0]          half_period,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_op,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_mask,
    input  logic [$clog2(DATA_W)-1:0] req_pos,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      busy,
    output logic                      done,
    output logic [DATA_W-1:0]         rdata,
    output logic                      ss_n,
    output logic                      sck,
    output logic                      mosi,
    input  logic                      miso
);
    localparam int FRAME_W = 2 * DATA_W;

    logic               xfer_start;
    logic [FRAME_W-1:0] xfer_word;
    logic               xfer_idle;
    logic               xfer_done;
    logic [FRAME_W-1:0] xfer_rx;

    spireg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_mask  (req_mask),
        .req_pos   (req_pos),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .xfer_start(xfer_start),
        .xfer_word (xfer_word),
        .xfer_idle (xfer_idle),
        .xfer_done (xfer_done),
        .xfer_rx   (xfer_rx)
    );

    spireg_shifter #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_period(half_period),
        .start      (xfer_start),
        .tx_word    (xfer_word),
        .idle       (xfer_idle),
        .done       (xfer_done),
        .rx_word    (xfer_rx),
        .ss_n       (ss_n),
        .sck        (sck),
        .mosi       (mosi),
        .miso       (miso)
    );

    // R3: the select never drops while the frame engine reports idle
    p_ss_only_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_idle |-> ss_n);
endmodule

// File: tb/sim_spi_reg_master.sv
module sim_spi_reg_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_period = 8'd0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'd0;
    logic [5:0] req_addr = 6'd0;
    logic [7:0] req_mask = 8'd0;
    logic [2:0] req_pos = 3'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       busy, done;
    logic [7:0] rdata;
    logic       ss_n, sck, mosi;
    logic       miso = 1'b0;

    always #2 clk = ~clk;

    spi_reg_master u0 (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_mask(req_mask), .req_pos(req_pos),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- slave register file model ----------------
    logic [7:0]  sregs [64];
    logic [7:0]  mregs [64];
    logic        slave_en = 1'b0;
    logic [15:0] s_in;
    logic [7:0]  s_out;
    int          s_cnt;
    logic [7:0]  log_cmd [256];
    logic [7:0]  log_dat [256];
    int          log_bits [256];
    int          log_n = 0;
    int          r4_bad = 0;

    always @(negedge ss_n) if (slave_en) begin
        s_cnt = 0; s_in = 16'h0; miso = 1'b0;
        if (sck !== 1'b0) r4_bad++;
    end
    always @(posedge sck) if (slave_en && !ss_n) begin
        s_in = {s_in[14:0], mosi};
        s_cnt++;
        if (s_cnt == 16 && s_in[15:14] == 2'b11) sregs[s_in[13:8]] = s_in[7:0];
    end
    always @(negedge sck) if (slave_en && !ss_n) begin
        if (s_cnt == 8) begin
            s_out = (s_in[7:6] == 2'b10) ? sregs[s_in[5:0]] : 8'h00;
            miso = s_out[7];
        end else if (s_cnt > 8) begin
            s_out = {s_out[6:0], 1'b0};
            miso = s_out[7];
        end
    end
    always @(posedge ss_n) if (slave_en) begin
        log_cmd[log_n % 256] = s_in[15:8];
        log_dat[log_n % 256] = s_in[7:0];
        log_bits[log_n % 256] = s_cnt;
        log_n++;
    end

    // ---------------- timing monitor ----------------
    int  gap_cnt = 0, run_cnt = 0, r8_bad = 0, r10_bad = 0;
    logic prev_ss = 1'b1, prev_sck = 1'b0, seen_frame = 1'b0;
    always @(negedge clk) if (slave_en) begin
        if (ss_n && sck) r4_bad++;
        if (prev_ss && !ss_n) begin
            if (seen_frame && gap_cnt < 2 * (half_period + 1)) r8_bad++;
            run_cnt = 1;
            seen_frame = 1'b1;
        end else if (!ss_n) begin
            if (sck != prev_sck) begin
                if (run_cnt != half_period + 1) r10_bad++;
                run_cnt = 1;
            end else run_cnt++;
        end
        if (ss_n) gap_cnt = prev_ss ? gap_cnt + 1 : 1;
        prev_ss = ss_n; prev_sck = sck;
    end

    // ---------------- request driver ----------------
    int busy_bad = 0;
    task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [7:0] m,
                         input logic [2:0] p, input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_mask = m; req_pos = p; req_wdata = v;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [7:0] got);
        while (!done) begin
            if (!busy || req_ready) busy_bad++;
            @(negedge clk);
        end
        if (busy) busy_bad++;
        got = rdata;
    endtask

    task automatic run_req(input logic [1:0] op, input logic [5:0] a, input logic [7:0] m,
                           input logic [2:0] p, input logic [7:0] v, output logic [7:0] got);
        issue(op, a, m, p, v);
        wait_done(got);
    endtask

    function automatic logic [7:0] merge(input logic [7:0] r, input logic [7:0] m,
                                         input logic [2:0] p, input logic [7:0] v);
        return (r & ~m) | ((v << p) & m);
    endfunction

    task automatic run_config(input logic [7:0] h, input int step);
        logic [7:0] got, exp, m;
        int l0;
        half_period = h;
        // R2 then R1: write every stepped address, read it back
        for (int a = 0; a < 64; a += step) begin
            exp = 8'(a * 29 + h * 7 + 3);
            l0 = log_n;
            run_req(2'd1, 6'(a), 8'h00, 3'd0, exp, got);
            chk("R2 rdata", got == exp, got, exp);
            chk("R2 frame", log_cmd[l0 % 256] == (8'hC0 | 8'(a)) && log_dat[l0 % 256] == exp,
                {log_cmd[l0 % 256], log_dat[l0 % 256]}, {8'hC0 | 8'(a), exp});
            mregs[a] = exp;
            l0 = log_n;
            run_req(2'd0, 6'(a), 8'h00, 3'd0, 8'h00, got);
            chk("R1 rdata", got == mregs[a], got, mregs[a]);
            chk("R1 frame", log_cmd[l0 % 256] == (8'h80 | 8'(a)) && log_dat[l0 % 256] == 8'h00,
                {log_cmd[l0 % 256], log_dat[l0 % 256]}, {8'h80 | 8'(a), 8'h00});
            chk("R3 bits", log_bits[l0 % 256] == 16 && log_n == l0 + 1, log_bits[l0 % 256], 16);
        end
        // R5 and R6: every contiguous field at every position
        for (int p = 0; p < 8; p++) begin
            for (int w = 1; w <= 8 - p; w++) begin
                int a;
                a = (p * 8 + w * 3) % 64;
                m = 8'(((1 << w) - 1) << p);
                exp = (mregs[a] & m) >> p;
                l0 = log_n;
                run_req(2'd2, 6'(a), m, 3'(p), 8'h00, got);
                chk("R5 field read", got == exp && log_n == l0 + 1, got, exp);
                exp = merge(mregs[a], m, 3'(p), 8'(p * 11 + w * 5 + h));
                l0 = log_n;
                run_req(2'd3, 6'(a), m, 3'(p), 8'(p * 11 + w * 5 + h), got);
                chk("R6 rdata", got == exp, got, exp);
                chk("R6 frames", log_n == l0 + 2 && log_cmd[l0 % 256] == (8'h80 | 8'(a))
                    && log_cmd[(l0 + 1) % 256] == (8'hC0 | 8'(a)) && log_dat[(l0 + 1) % 256] == exp,
                    {log_cmd[(l0 + 1) % 256], log_dat[(l0 + 1) % 256]}, {8'hC0 | 8'(a), exp});
                mregs[a] = exp;
                chk("R6 register", sregs[a] == exp, sregs[a], exp);
            end
        end
        chk("R8 select gap", r8_bad == 0, r8_bad, 0);
        chk("R10 half period", r10_bad == 0, r10_bad, 0);
        chk("R4 sck idle low", r4_bad == 0, r4_bad, 0);
        chk("R9 busy window", busy_bad == 0, busy_bad, 0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] got, exp;
        int l0, ready_seen;
        for (int i = 0; i < 64; i++) begin sregs[i] = 8'(i * 37 + 5); mregs[i] = 8'(i * 37 + 5); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset", ss_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && done == 1'b0 && req_ready == 1'b1,
            {ss_n, sck, busy, done, req_ready}, 5'b10001);
        slave_en = 1'b1;
        prev_ss = ss_n;

        run_config(8'd0, 1);
        run_config(8'd1, 1);
        run_config(8'd3, 9);

        // R7: plain write held valid through a field update on the same address
        half_period = 8'd1;
        exp = merge(mregs[5], 8'h3C, 3'd2, 8'h0A);
        l0 = log_n;
        issue(2'd3, 6'd5, 8'h3C, 3'd2, 8'h0A);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 6'd5; req_wdata = 8'h5A;
        ready_seen = 0;
        while (!done) begin
            if (req_ready) ready_seen++;
            @(negedge clk);
        end
        chk("R7 held off", ready_seen == 0, ready_seen, 0);
        chk("R6 rdata under contention", rdata == exp, rdata, exp);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(got);
        chk("R7 frame order", log_n == l0 + 3 && log_cmd[l0 % 256] == 8'h85 && log_cmd[(l0 + 1) % 256] == 8'hC5
            && log_dat[(l0 + 1) % 256] == exp && log_dat[(l0 + 2) % 256] == 8'h5A,
            {log_dat[(l0 + 1) % 256], log_dat[(l0 + 2) % 256]}, {exp, 8'h5A});
        chk("R7 final register", sregs[5] == 8'h5A, sregs[5], 8'h5A);
        chk("R9 busy window", busy_bad == 0, busy_bad, 0);
        chk("R3 idle select", ss_n == 1'b1, ss_n, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule